// File: doc/BRIEF.md
# Infrared Transceiver Control Core

This block is the digital controller that sits between a serial encoder and the analog parts of an infrared link front end. It takes a shutdown request, the transmit data bit and a digitized "light present" flag from the receiver. From these it derives the LED drive enable, the active-low receive data with its output enable, and a receiver bandwidth selection bit.

Shutdown is entered only after the shutdown request has stayed high for longer than a programmable number of cycles. A short pulse on the request is therefore a command, not a power-down. Each falling edge of the request samples the transmit bit and stores it as the bandwidth mode. This lets a host select low or high receiver bandwidth by wiggling the two inputs. An eye-safety guard turns the LED off once transmit data has been held high for too long. The LED stays off until transmit data returns low.

All inputs are assumed synchronous to `clk_i`. Time limits are given as cycle counts through parameters.

Top module: `ir_xcvr_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (low bandwidth), `led_en_o` is 0, `rxd_oe_o` is 1 and, with no light, `rxd_o` is 1.
- R2: Shutdown is entered once `sd_i` has been sampled high on more than `SHDN_CYCLES` consecutive clock edges; in shutdown `rxd_oe_o` is 0. Exactly `SHDN_CYCLES` high samples do not enter shutdown.
- R3: A low sample of `sd_i` leaves shutdown from the following cycle and restarts the shutdown count.
- R4: On every clock edge where `sd_i` is sampled low after having been sampled high on the previous edge, `mode_o` takes the sampled `txd_i` value (1 = high bandwidth, 0 = low bandwidth).
- R5: `mode_o` changes on no other edge, whatever `txd_i` does.
- R6: `led_en_o` equals `txd_i` while `sd_i` is low, the block is not in shutdown and the timeout has not tripped.
- R7: Once `txd_i` has been sampled high on more than `LED_MAX_CYCLES` consecutive edges, `led_en_o` is 0 until `txd_i` is sampled low; a later high turns the LED on again.
- R8: With `sd_i` low, `txd_i` low and not in shutdown, `rxd_o` is the inverse of `light_i`.
- R9: While `led_en_o` is 1, `rxd_o` is 0 (the receiver echoes the block's own transmission).
- R10: While `sd_i` is high, `led_en_o` is 0 and `rxd_o` is 1, whatever `light_i` and `txd_i` do.
- R11: In shutdown, `led_en_o` is 0 and `rxd_o` is 1 regardless of `light_i`.
- R12: Leaving shutdown arms the timeout: if `txd_i` is still high, the LED stays off until `txd_i` goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_i | input | 1 | Shutdown request and mode strobe, active high |
| txd_i | input | 1 | Transmit data, active high |
| light_i | input | 1 | Digitized in-band light detected flag |
| led_en_o | output | 1 | LED drive enable |
| rxd_o | output | 1 | Receive data, active low |
| rxd_oe_o | output | 1 | Output enable for `rxd_o` (0 = tri-state) |
| mode_o | output | 1 | Receiver bandwidth: 0 low, 1 high |

## Verification
Receive activity is applied with transmit idle, and short transmit bursts are applied with light both on and off. This separates the pure receive path from the echo path. Transmit is held high past the limit and then released and raised again, which shows that the trip latches and clears on a low sample. Request pulses with transmit high or low at the falling edge show that the mode latches on the edge only. Request holds of exactly the threshold and one cycle longer pin down the shutdown boundary. A shutdown exit with transmit still high shows that the guard re-arms.

// File: rtl/ir_xcvr_pkg.sv
package ir_xcvr_pkg;
  typedef enum logic {
    BW_LOW  = 1'b0,
    BW_HIGH = 1'b1
  } bw_mode_e;

  localparam bw_mode_e BW_RESET = BW_LOW;
endpackage

// File: rtl/ir_sat_cnt.sv
module ir_sat_cnt #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);
  localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && (cnt_q != LIM))  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LIM);

  assert_cnt_saturates_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  assert_cnt_clears_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ir_shdn_det.sv
module ir_shdn_det #(
  parameter int unsigned SHDN_CYCLES = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sd_i,
  output logic shdn_o
);
  logic hold_full;
  logic shdn_q;

  ir_sat_cnt #(.LIMIT(SHDN_CYCLES)) u_hold_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~sd_i),
    .inc_i  (sd_i),
    .full_o (hold_full)
  );

  // full before this edge means SHDN_CYCLES prior highs; this high makes one more
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shdn_q <= 1'b0;
    else         shdn_q <= sd_i & hold_full;
  end

  assign shdn_o = shdn_q;

  assert_shdn_exit_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_i |=> !shdn_q);
endmodule

// File: rtl/ir_bw_latch.sv
module ir_bw_latch
  import ir_xcvr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sd_i,
  input  logic     txd_i,
  output bw_mode_e mode_o
);
  logic     sd_prev_q;
  logic     sd_fall;
  bw_mode_e mode_q;

  assign sd_fall = sd_prev_q & ~sd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_prev_q <= 1'b0;
      mode_q    <= BW_RESET;
    end else begin
      sd_prev_q <= sd_i;
      if (sd_fall) mode_q <= bw_mode_e'(txd_i);
    end
  end

  assign mode_o = mode_q;

  assert_mode_capture_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_fall |=> (mode_q == bw_mode_e'($past(txd_i))));

  assert_mode_hold_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_fall |=> $stable(mode_q));
endmodule

// File: rtl/ir_led_guard.sv
module ir_led_guard #(
  parameter int unsigned LED_MAX_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic shdn_i,
  output logic blocked_o
);
  logic on_full;
  logic blocked_q;

  ir_sat_cnt #(.LIMIT(LED_MAX_CYCLES)) u_on_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (shdn_i | ~txd_i),
    .inc_i  (txd_i),
    .full_o (on_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      blocked_q <= 1'b0;
    else if (shdn_i)  blocked_q <= 1'b1;  // re-arm: wait for a low txd after wake
    else if (!txd_i)  blocked_q <= 1'b0;
    else if (on_full) blocked_q <= 1'b1;
  end

  assign blocked_o = blocked_q;

  assert_block_release_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blocked_q) |-> !$past(txd_i));

  assert_wake_armed_R12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> blocked_q);
endmodule

// File: rtl/ir_xcvr_ctrl.sv
module ir_xcvr_ctrl
  import ir_xcvr_pkg::*;
#(
  parameter int unsigned SHDN_CYCLES    = 4000,
  parameter int unsigned LED_MAX_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sd_i,
  input  logic txd_i,
  input  logic light_i,
  output logic led_en_o,
  output logic rxd_o,
  output logic rxd_oe_o,
  output logic mode_o
);
  logic     shdn;
  logic     blocked;
  logic     rx_active;
  bw_mode_e mode;

  ir_shdn_det #(.SHDN_CYCLES(SHDN_CYCLES)) u_shdn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sd_i   (sd_i),
    .shdn_o (shdn)
  );

  ir_bw_latch u_bw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sd_i   (sd_i),
    .txd_i  (txd_i),
    .mode_o (mode)
  );

  ir_led_guard #(.LED_MAX_CYCLES(LED_MAX_CYCLES)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .txd_i     (txd_i),
    .shdn_i    (shdn),
    .blocked_o (blocked)
  );

  assign rx_active = ~sd_i & ~shdn;
  assign led_en_o  = txd_i & rx_active & ~blocked;
  assign rxd_o     = ~((light_i & rx_active) | led_en_o);
  assign rxd_oe_o  = ~shdn;
  assign mode_o    = mode;

  assert_shdn_quiet_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxd_oe_o |-> (!led_en_o && rxd_o));

  assert_echo_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_en_o |-> !rxd_o);

  assert_sd_led_off_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |-> !led_en_o);
endmodule

// File: tb/ir_xcvr_ctrl_tb.sv
module ir_xcvr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SHDN = 12;
  localparam int LEDM = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sd = 1'b0, txd = 1'b0, light = 1'b0;
  logic led_en, rxd, rxd_oe, mode;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // reference model state
  bit m_shdn = 0, m_mode = 0, m_blocked = 0, m_sdprev = 0;
  int m_hsd = 0, m_htx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_xcvr_ctrl #(.SHDN_CYCLES(SHDN), .LED_MAX_CYCLES(LEDM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sd_i(sd), .txd_i(txd), .light_i(light),
    .led_en_o(led_en), .rxd_o(rxd), .rxd_oe_o(rxd_oe), .mode_o(mode)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_led, e_rxd;
    e_led = txd && !sd && !m_shdn && !m_blocked;
    e_rxd = !((light && !sd && !m_shdn) || e_led);
    chk("led_en_o", led_en, e_led);
    chk("rxd_o", rxd, e_rxd);
    chk("rxd_oe_o", rxd_oe, !m_shdn);
    chk("mode_o", mode, m_mode);
  endtask

  task automatic model_edge();
    bit old_shdn;
    old_shdn = m_shdn;
    m_hsd = sd ? m_hsd + 1 : 0;
    m_shdn = (m_hsd > SHDN);
    if (m_sdprev && !sd) m_mode = txd;
    m_htx = (old_shdn || !txd) ? 0 : m_htx + 1;
    m_blocked = old_shdn || (txd && (m_blocked || m_htx > LEDM));
    m_sdprev = sd;
  endtask

  task automatic step(input logic s, input logic t, input logic l, input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sd = s; txd = t; light = l;
      #1 compare();
      @(posedge clk);
      model_edge();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    @(negedge clk);
    rst_ni = 1'b1;
    cur_req = "R1"; step(0, 0, 0, 3);
    // receive path, transmit idle
    cur_req = "R8"; step(0, 0, 1, 2); step(0, 0, 0); step(0, 0, 1); step(0, 0, 0, 2);
    // short bursts with and without light
    cur_req = "R6"; step(0, 1, 0, 3); step(0, 0, 0, 2);
    cur_req = "R9"; step(0, 1, 1, 3); step(0, 0, 1); step(0, 1, 0, 2); step(0, 0, 0);
    // stuck-high guard; exactly LEDM highs then release is still fine
    cur_req = "R7"; step(0, 1, 0, LEDM); step(0, 0, 0);
    step(0, 1, 1, LEDM + 6); step(0, 1, 0, 2); step(0, 0, 0, 2); step(0, 1, 0, 3); step(0, 0, 0);
    // mode programming
    cur_req = "R4"; step(1, 0, 0); step(1, 1, 0, 2); step(0, 1, 0); step(0, 0, 0, 2);
    cur_req = "R5"; step(0, 1, 0); step(0, 0, 1); step(0, 1, 1, 2); step(0, 0, 0, 2);
    cur_req = "R10"; step(1, 0, 1, 3); step(1, 1, 1, 2); step(1, 0, 0); step(0, 0, 0, 2);
    cur_req = "R4"; step(1, 1, 0, 2); step(0, 1, 0); step(0, 0, 0, 2);
    // shutdown boundary: exactly SHDN highs do not shut down
    cur_req = "R2"; step(1, 0, 0, SHDN); step(0, 0, 0, 2);
    step(1, 0, 1, SHDN + 4);
    cur_req = "R11"; step(1, 1, 1, 3); step(1, 0, 1, 2);
    cur_req = "R3"; step(0, 0, 1, 2); step(0, 0, 0, 2);
    // wake with txd high
    cur_req = "R12"; step(1, 1, 0, SHDN + 3); step(0, 1, 0, 4); step(0, 0, 0); step(0, 1, 0, 3); step(0, 0, 0, 2);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule